// File: doc/BRIEF.md
# String Loop Engine

A multi-cycle engine that carries out the block string operations of a CPU. The core hands it a snapshot of three registers: a first pointer (R1), a second pointer or comparison value (R2) and an element count (R3). It also passes the current zero and carry flags, an opcode and an element size code, all with a one-cycle start pulse. The engine then walks memory through a single request/response port, with at most one access per cycle. When it finishes it raises `done` for one cycle. The updated registers and flags are valid in that same cycle and are written back by the core.

The engine covers seven loop kinds:
- copy forward;
- copy backward;
- copy until a zero byte;
- fill;
- search until equal;
- search while equal;
- compare until mismatch.

Each loop kind has its own stride, direction and stop rule. Read requests are answered by `mem_rvalid` on some later cycle, with the element in the low bits of `mem_rdata`. The engine ignores any bits above the element size. A write completes in the cycle it is requested and is little-endian.

Top module: `str_loop_engine`

## Requirements
- R1: After reset, `done` and `mem_req` are low until a start pulse arrives.
- R2: Opcode 0 (copy forward) reads a byte at R2 and writes it to R1, once per element. Both pointers rise by 1 and R3 falls by 1 per element, and the loop stops when R3 reaches 0.
- R3: Opcode 1 (copy backward) behaves like opcode 0, except that both pointers fall by 1 per element.
- R4: Opcode 2 (copy until zero) copies forward like opcode 0. It also stops right after a zero byte has been written, leaving R3 at the count still remaining.
- R5: Opcode 3 (fill) writes the low 1, 2 or 4 bytes of R2 to R1, little-endian, for size code 0, 1 or 2. It advances R1 by that many bytes and lowers R3 by 1 per element until R3 is 0; R2 is unchanged.
- R6: Opcode 4 (search until equal) reads zero-extended elements at R1 and advances R1 by the element size, lowering R3 each time. It stops when an element equals R2 or R3 reaches 0. At the end, Z is 1 only if the last element equals R2, and C is 1 if that element is at most R2.
- R7: Opcode 5 (search while equal) reads elements like opcode 4, but stops when an element differs from R2 or R3 reaches 0. At the end, Z is 1 only if the final R3 is 0, and C is 1 if the last element is at most R2.
- R8: Opcode 6 (compare until mismatch) reads a byte at R1 and then a byte at R2. It advances both pointers by 1 and lowers R3 by 1 per pair. It stops on unequal bytes, on a zero byte, or when R3 reaches 0. At the end, Z is 1 if the last pair was equal, and C is 1 if the R1 byte is at least the R2 byte.
- R9: With R3 equal to 0 at start, the engine makes no memory access and returns R1, R2, R3, Z and C unchanged. The copy and fill opcodes always return Z and C unchanged.
- R10: `done` is high for exactly one cycle per operation, and R3 never steps below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse, taken when idle |
| op | input | 3 | Opcode 0..6 |
| size | input | 2 | Element size code: 0 byte, 1 halfword, 2 word |
| r1_in | input | W | First pointer at start |
| r2_in | input | W | Second pointer or value at start |
| r3_in | input | W | Element count at start |
| z_in | input | 1 | Zero flag at start |
| c_in | input | 1 | Carry flag at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | Access size code |
| mem_addr | output | W | Byte address |
| mem_wdata | output | W | Write data, low bytes used |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data, low bytes used |
| done | output | 1 | Operation finished, outputs valid |
| r1_out | output | W | Final R1 |
| r2_out | output | W | Final R2 |
| r3_out | output | W | Final R3 |
| z_out | output | 1 | Final zero flag |
| c_out | output | 1 | Final carry flag |

## Verification
The assertions watch, on every cycle, four properties:
- `done` is a single-cycle pulse.
- R3 is never zero when an element step is about to be issued.
- Each write step lowers R3 by exactly one.
- The copy and fill loops always end with a zero count, and search-while-equal ends with Z matching a zero R3.

Only the bench scenarios can show the rest:
- memory contents and pointer direction;
- the early stop on a zero byte or a match;
- the flag values from the last element;
- the absence of any access when the count starts at zero.

// File: rtl/str_loop_engine.sv
module str_loop_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [1:0]   size,
  input  logic [W-1:0] r1_in,
  input  logic [W-1:0] r2_in,
  input  logic [W-1:0] r3_in,
  input  logic         z_in,
  input  logic         c_in,
  output logic         mem_req,
  output logic         mem_we,
  output logic [1:0]   mem_size,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata,
  output logic         done,
  output logic [W-1:0] r1_out,
  output logic [W-1:0] r2_out,
  output logic [W-1:0] r3_out,
  output logic         z_out,
  output logic         c_out
);
  localparam logic [2:0] OP_CPF = 3'd0, OP_CPB = 3'd1, OP_CPZ = 3'd2, OP_FILL = 3'd3,
                         OP_SUNT = 3'd4, OP_SWH = 3'd5, OP_CMP = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_RDA, S_WTA, S_RDB, S_WTB, S_WR, S_DONE} st_t;
  st_t st;

  logic [2:0]   op_q;
  logic [1:0]   sz_q;
  logic [W-1:0] r1_q, r2_q, r3_q, ta;
  logic         z_q, c_q;

  wire is_copy  = (op_q == OP_CPF) || (op_q == OP_CPB) || (op_q == OP_CPZ);
  wire is_srch  = (op_q == OP_SUNT) || (op_q == OP_SWH);
  wire last_cnt = (r3_q == W'(1));
  wire [W-1:0] stride = (sz_q == 2'd0) ? W'(1) : (sz_q == 2'd1) ? W'(2) : W'(4);
  wire [1:0]   esz    = (is_srch || op_q == OP_FILL) ? sz_q : 2'd0;
  wire [W-1:0] rd_ext = (esz == 2'd0) ? W'(mem_rdata[7:0]) :
                        (esz == 2'd1) ? W'(mem_rdata[15:0]) : W'(mem_rdata[31:0]);

  assign mem_req   = (st == S_RDA) || (st == S_RDB) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_size  = esz;
  assign mem_addr  = ((st == S_RDA && is_copy) || st == S_RDB) ? r2_q : r1_q;
  assign mem_wdata = (op_q == OP_FILL) ? r2_q : ta;
  assign done      = (st == S_DONE);
  assign r1_out = r1_q;
  assign r2_out = r2_q;
  assign r3_out = r3_q;
  assign z_out  = z_q;
  assign c_out  = c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0; sz_q <= '0;
      r1_q <= '0; r2_q <= '0; r3_q <= '0; ta <= '0;
      z_q <= 1'b0; c_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q <= op; sz_q <= size;
          r1_q <= r1_in; r2_q <= r2_in; r3_q <= r3_in;
          z_q <= z_in; c_q <= c_in;
          if (r3_in == '0) st <= S_DONE;
          else if (op == OP_FILL) st <= S_WR;
          else st <= S_RDA;
        end
        S_RDA: st <= S_WTA;
        S_WTA: if (mem_rvalid) begin
          ta <= rd_ext;
          if (is_copy) st <= S_WR;
          else if (op_q == OP_CMP) st <= S_RDB;
          else begin
            r1_q <= r1_q + stride;
            r3_q <= r3_q - W'(1);
            c_q  <= (rd_ext <= r2_q);
            z_q  <= (op_q == OP_SUNT) ? (rd_ext == r2_q) : last_cnt;
            if (last_cnt || ((op_q == OP_SUNT) == (rd_ext == r2_q))) st <= S_DONE;
            else st <= S_RDA;
          end
        end
        S_RDB: st <= S_WTB;
        S_WTB: if (mem_rvalid) begin
          r1_q <= r1_q + W'(1);
          r2_q <= r2_q + W'(1);
          r3_q <= r3_q - W'(1);
          z_q  <= (ta[7:0] == rd_ext[7:0]);
          c_q  <= (ta[7:0] >= rd_ext[7:0]);
          if (last_cnt || ta[7:0] != rd_ext[7:0] || ta[7:0] == 8'd0) st <= S_DONE;
          else st <= S_RDA;
        end
        S_WR: begin
          r3_q <= r3_q - W'(1);
          if (op_q == OP_FILL) r1_q <= r1_q + stride;
          else if (op_q == OP_CPB) begin
            r1_q <= r1_q - W'(1); r2_q <= r2_q - W'(1);
          end else begin
            r1_q <= r1_q + W'(1); r2_q <= r2_q + W'(1);
          end
          if (last_cnt || (op_q == OP_CPZ && ta[7:0] == 8'd0)) st <= S_DONE;
          else if (op_q == OP_FILL) st <= S_WR;
          else st <= S_RDA;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: single-cycle completion pulse
  p_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10: count never stepped from zero
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDA || st == S_WR) |-> r3_q != '0);
  // R5: every write step consumes one element
  p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |=> r3_q == $past(r3_q) - W'(1));
  // R2 R3 R5: counted copies and fill end with an empty count
  p_copy_ends_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_CPF || op_q == OP_CPB || op_q == OP_FILL)) |-> r3_out == '0);
  // R7: search-while zero flag follows the remaining count
  p_while_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_SWH && $past(st) == S_WTA) |-> z_out == (r3_out == '0));
endmodule

// File: tb/test_str_loop_engine.sv
`timescale 1ns/1ps
module test_str_loop_engine;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [1:0] size = 0;
  logic [W-1:0] r1_in = 0, r2_in = 0, r3_in = 0;
  logic z_in = 0, c_in = 0;
  logic mem_req, mem_we, mem_rvalid = 0, done, z_out, c_out;
  logic [1:0] mem_size;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata = 0, r1_out, r2_out, r3_out;
  logic [7:0] mem [0:255];
  int nreq = 0, checks = 0, fails = 0;

  always #2 clk = ~clk;

  str_loop_engine #(.W(W)) i_str_loop_engine (.*);

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      nreq <= nreq + 1;
      if (mem_we) begin
        for (int b = 0; b < (1 << mem_size); b++)
          mem[8'(mem_addr + W'(b))] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= {mem[8'(mem_addr+3)], mem[8'(mem_addr+2)], mem[8'(mem_addr+1)], mem[8'(mem_addr[7:0])]};
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [1:0] s, input logic [W-1:0] a, b, n,
                     input logic zi, ci);
    int t = 0;
    @(negedge clk);
    op = o; size = s; r1_in = a; r2_in = b; r3_in = n; z_in = zi; c_in = ci; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) chk(0, "R10 watchdog", 0, 1);
  endtask

  task automatic regs(input string tag, input logic [W-1:0] a, b, n);
    chk(r1_out == a, {tag, " r1"}, r1_out, a);
    chk(r2_out == b, {tag, " r2"}, r2_out, b);
    chk(r3_out == n, {tag, " r3"}, r3_out, n);
  endtask

  task automatic flags(input string tag, input logic z, c);
    chk(z_out == z, {tag, " z"}, W'(z_out), W'(z));
    chk(c_out == c, {tag, " c"}, W'(c_out), W'(c));
  endtask

  task automatic t_reset;
    chk(!done && !mem_req, "R1 idle after reset", W'({done, mem_req}), 0);
  endtask

  task automatic t_copy_fwd;
    mem[8'h10] = 8'h11; mem[8'h11] = 8'h22; mem[8'h12] = 8'h33;
    run(0, 0, 32'h40, 32'h10, 3, 1, 0);
    regs("R2 copy fwd", 32'h43, 32'h13, 0);
    flags("R9 copy flags kept", 1, 0);
    chk({mem[8'h40], mem[8'h41], mem[8'h42]} == 24'h112233, "R2 copy data",
        W'({mem[8'h40], mem[8'h41], mem[8'h42]}), 32'h112233);
    @(negedge clk);
    chk(!done, "R10 done one cycle", W'(done), 0);
  endtask

  task automatic t_copy_bwd;
    mem[8'h22] = 8'hA1; mem[8'h21] = 8'hA2; mem[8'h20] = 8'hA3;
    run(1, 0, 32'h52, 32'h22, 3, 0, 1);
    regs("R3 copy bwd", 32'h4F, 32'h1F, 0);
    chk({mem[8'h52], mem[8'h51], mem[8'h50]} == 24'hA1A2A3, "R3 copy bwd data",
        W'({mem[8'h52], mem[8'h51], mem[8'h50]}), 32'hA1A2A3);
  endtask

  task automatic t_copy_zero;
    mem[8'h30] = 8'h41; mem[8'h31] = 8'h00; mem[8'h32] = 8'h43; mem[8'h62] = 8'hEE;
    run(2, 0, 32'h60, 32'h30, 5, 0, 0);
    regs("R4 copy until zero", 32'h62, 32'h32, 3);
    chk(mem[8'h61] == 8'h00 && mem[8'h62] == 8'hEE, "R4 stop after zero",
        W'({mem[8'h61], mem[8'h62]}), 32'h00EE);
  endtask

  task automatic t_fill;
    mem[8'h86] = 8'h77;
    run(3, 2, 32'h70, 32'hDEADBEEF, 2, 0, 0);
    regs("R5 fill word", 32'h78, 32'hDEADBEEF, 0);
    chk({mem[8'h77], mem[8'h76], mem[8'h75], mem[8'h74]} == 32'hDEADBEEF, "R5 fill word data",
        {mem[8'h77], mem[8'h76], mem[8'h75], mem[8'h74]}, 32'hDEADBEEF);
    run(3, 1, 32'h80, 32'h1234, 3, 0, 0);
    regs("R5 fill half", 32'h86, 32'h1234, 0);
    chk({mem[8'h85], mem[8'h84], mem[8'h86]} == 24'h123477, "R5 fill half data",
        W'({mem[8'h85], mem[8'h84], mem[8'h86]}), 32'h123477);
    run(3, 0, 32'h90, 32'hAB, 2, 0, 0);
    chk(r1_out == 32'h92 && mem[8'h91] == 8'hAB, "R5 fill byte", r1_out, 32'h92);
  endtask

  task automatic t_search_until;
    mem[8'hA0] = 8'h05; mem[8'hA1] = 8'h07; mem[8'hA2] = 8'h09; mem[8'hA3] = 8'h0B;
    run(4, 0, 32'hA0, 9, 4, 0, 0);
    regs("R6 search hit", 32'hA3, 9, 1);
    flags("R6 search hit", 1, 1);
    run(4, 0, 32'hA0, 8, 4, 1, 1);
    regs("R6 search miss", 32'hA4, 8, 0);
    flags("R6 search miss", 0, 0);
    mem[8'hB0] = 8'h11; mem[8'hB1] = 8'h11; mem[8'hB2] = 8'h22; mem[8'hB3] = 8'h22;
    run(4, 1, 32'hB0, 32'h2222, 5, 0, 0);
    regs("R6 search half", 32'hB4, 32'h2222, 3);
    flags("R6 search half", 1, 1);
  endtask

  task automatic t_search_while;
    mem[8'hC0] = 8'h07; mem[8'hC1] = 8'h07; mem[8'hC2] = 8'h09;
    run(5, 0, 32'hC0, 7, 5, 1, 1);
    regs("R7 while differ", 32'hC3, 7, 2);
    flags("R7 while differ", 0, 0);
    run(5, 0, 32'hC0, 7, 2, 0, 0);
    regs("R7 while exhaust", 32'hC2, 7, 0);
    flags("R7 while exhaust", 1, 1);
  endtask

  task automatic t_compare;
    mem[8'hD0] = 8'h61; mem[8'hD1] = 8'h62; mem[8'hD2] = 8'h63;
    mem[8'hE0] = 8'h61; mem[8'hE1] = 8'h62; mem[8'hE2] = 8'h78;
    run(6, 0, 32'hD0, 32'hE0, 10, 1, 1);
    regs("R8 compare mismatch", 32'hD3, 32'hE3, 7);
    flags("R8 compare mismatch", 0, 0);
    mem[8'hE8] = 8'h61; mem[8'hE9] = 8'h00; mem[8'hF0] = 8'h61; mem[8'hF1] = 8'h00;
    run(6, 0, 32'hE8, 32'hF0, 10, 0, 0);
    regs("R8 compare zero", 32'hEA, 32'hF2, 8);
    flags("R8 compare zero", 1, 1);
    run(6, 0, 32'hE8, 32'hF0, 1, 0, 0);
    regs("R8 compare count", 32'hE9, 32'hF1, 0);
    flags("R8 compare count", 1, 1);
  endtask

  task automatic t_zero_count;
    int n0 = nreq;
    run(4, 0, 32'hA0, 5, 0, 0, 1);
    regs("R9 zero count", 32'hA0, 5, 0);
    flags("R9 zero count", 0, 1);
    run(6, 0, 32'hD0, 32'hE0, 0, 1, 0);
    flags("R9 zero count cmp", 1, 0);
    chk(nreq == n0, "R9 no access", W'(nreq - n0), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_copy_fwd();
    t_copy_bwd();
    t_copy_zero();
    t_fill();
    t_search_until();
    t_search_while();
    t_compare();
    t_zero_count();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL R10 watchdog expired: got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule